// File: doc/BRIEF.md
# Byte/Word Logic and Left-Shift Execution Unit

This unit is one execution slot of a 16-bit processor core. When a valid strobe arrives it takes an opcode, a size select, a destination operand, a source operand (or a shift count) and the current arithmetic flags. It computes one of: bitwise AND, OR, XOR, NOT, a flag-only TEST, or a left shift that brings zeros in at the bottom. It then returns the new destination value, a write-enable for that destination, the updated carry, overflow, parity, sign and zero flags, and a one-cycle done pulse.

The unit runs on byte or word operands. In byte mode only the low eight bits take part. The upper byte of the returned value is the destination's upper byte, unchanged. The bitwise operations finish in a fixed two cycles. The shift moves one bit position per clock, so its latency grows with the count. While an operation is in flight the unit reports busy and ignores further strobes. Register-file access, decode and memory operands stay with the surrounding pipeline.

Top module: `blsu_top`

## Requirements
- R1: Opcode codes are 0 = AND, 1 = OR, 2 = XOR, 3 = NOT, 4 = TEST, 5 = SHL. For AND, OR and XOR the returned value is the bitwise combination of destination and source, and `resWe` is 1 with the done pulse.
- R2: NOT returns the bitwise complement of the destination (F038h gives 0FC7h), writes it, and passes all five incoming flags through unchanged.
- R3: TEST computes destination AND source for the flags only. `resWe` is 0 and `resOut` shows the destination unchanged.
- R4: After AND, OR, XOR or TEST, CF and OF are both 0.
- R5: SF is the MSB of the result at the selected size. ZF is 1 when the result at that size is all zeros. PF is 1 when the low 8 bits of the result hold an even number of ones.
- R6: With `wordMode` = 0 only bits 7:0 are operated on, and `resOut[15:8]` equals `dstIn[15:8]`. With `wordMode` = 1 all 16 bits are operated on.
- R7: SHL shifts left by `srcIn[4:0]` positions with zero fill. CF is the last bit shifted out of the MSB of the selected size. A count at or beyond the size gives a zero result.
- R8: For SHL with count 1, OF = new MSB XOR new CF. For counts of 2 or more, OF keeps its incoming value.
- R9: SHL with count 0 does not write (`resWe` = 0, `resOut` = destination) and passes all incoming flags through.
- R10: Operations 0 to 4 and SHL with count 0 assert `doneOut` in the second cycle after the accepting edge. SHL with count c > 0 asserts it c cycles later. `doneOut` lasts exactly one cycle, and the outputs change only with it.
- R11: `busy` is 1 from the accepting edge until the edge that raises `doneOut`. A `validIn` seen while `busy` is 1 is ignored.
- R12: After reset, `doneOut`, `resWe`, `busy`, `resOut` and all flag outputs are 0. Opcodes 6 and 7 behave as a no-op: no write, the destination is returned, and the flags are passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Start strobe, taken when not busy |
| opSel | input | 3 | Operation code (see R1) |
| wordMode | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| dstIn | input | 16 | Destination operand |
| srcIn | input | 16 | Source operand; bits 4:0 are the shift count for SHL |
| cfIn | input | 1 | Incoming carry flag |
| ofIn | input | 1 | Incoming overflow flag |
| pfIn | input | 1 | Incoming parity flag |
| sfIn | input | 1 | Incoming sign flag |
| zfIn | input | 1 | Incoming zero flag |
| resOut | output | 16 | New destination value |
| resWe | output | 1 | Destination write-enable, only with doneOut |
| cfOut | output | 1 | Updated carry flag |
| ofOut | output | 1 | Updated overflow flag |
| pfOut | output | 1 | Updated parity flag |
| sfOut | output | 1 | Updated sign flag |
| zfOut | output | 1 | Updated zero flag |
| doneOut | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in flight |

## Verification
The bound checker watches, on every cycle, the properties that hold for any operation:
- `doneOut` is a single-cycle pulse that never follows an idle cycle directly.
- A write happens only with done, and TEST never writes.
- Bitwise operations clear CF and OF.
- ZF agrees with the written value.
- `resOut` holds still between completions.

The value-level behaviour shows up only in the bench's scenarios, because it depends on the exact operands and counts. This covers shifted-out carry bits, the one-bit overflow rule, upper-byte preservation in byte mode, pass-through of flags for NOT and zero counts, and strobes ignored while busy.

// File: rtl/blsu_pkg.sv
package blsu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_NOT  = 3'd3,
    OP_TEST = 3'd4,
    OP_SHL  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } blsuOp_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic pf;
    logic sf;
    logic zf;
  } blsuFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } blsuCtrl_t;

endpackage

// File: rtl/blsu_control.sv
module blsu_control
  import blsu_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [2:0]       opSel,
  input  logic [CNT_W-1:0] countIn,
  output blsuCtrl_t        ctrl,
  output logic             busy
);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_FIN} state_e;

  state_e           state;
  logic [CNT_W-1:0] cntR;
  logic             startShift;

  assign startShift = (blsuOp_e'(opSel) == OP_SHL) && (countIn != '0);

  always_comb begin
    ctrl.load   = (state == S_IDLE) && validIn;
    ctrl.step   = (state == S_STEP);
    ctrl.finish = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cntR  <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (validIn) begin
            if (startShift) begin
              state <= S_STEP;
              cntR  <= countIn;
            end else begin
              state <= S_FIN;
            end
          end
        end
        S_STEP: begin
          cntR <= cntR - 1'b1;
          if (cntR == {{(CNT_W-1){1'b0}}, 1'b1}) state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blsu_datapath.sv
module blsu_datapath
  import blsu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  blsuCtrl_t         ctrl,
  input  logic [2:0]        opSel,
  input  logic              wordMode,
  input  logic [WORD_W-1:0] dstIn,
  input  logic [WORD_W-1:0] srcIn,
  input  blsuFlags_t        flagsIn,
  output logic [WORD_W-1:0] resOut,
  output logic              resWe,
  output blsuFlags_t        flagsOut,
  output logic              doneOut
);

  localparam int HI_W = WORD_W - BYTE_W;

  blsuOp_e           opR;
  logic              wordR;
  logic [WORD_W-1:0] dstR;
  logic [WORD_W-1:0] workR;
  blsuFlags_t        savedR;
  logic              cfShR;
  logic              oneBitR;
  logic              zeroCntR;

  // sized views of the working value
  logic              msbNow;
  logic              zeroNow;
  logic              parityNow;
  logic [WORD_W-1:0] merged;
  logic              writeEn;
  blsuFlags_t        flagsNext;

  always_comb begin
    msbNow    = wordR ? workR[WORD_W-1] : workR[BYTE_W-1];
    zeroNow   = wordR ? (workR == '0) : (workR[BYTE_W-1:0] == '0);
    parityNow = ~^workR[7:0];
    merged    = wordR ? workR : {dstR[WORD_W-1:BYTE_W], workR[BYTE_W-1:0]};
  end

  always_comb begin
    writeEn   = 1'b0;
    flagsNext = savedR;
    unique case (opR)
      OP_AND, OP_OR, OP_XOR, OP_TEST: begin
        writeEn      = (opR != OP_TEST);
        flagsNext.cf = 1'b0;
        flagsNext.of = 1'b0;
        flagsNext.pf = parityNow;
        flagsNext.sf = msbNow;
        flagsNext.zf = zeroNow;
      end
      OP_NOT: writeEn = 1'b1;
      OP_SHL: begin
        if (!zeroCntR) begin
          writeEn      = 1'b1;
          flagsNext.cf = cfShR;
          flagsNext.of = oneBitR ? (msbNow ^ cfShR) : savedR.of;
          flagsNext.pf = parityNow;
          flagsNext.sf = msbNow;
          flagsNext.zf = zeroNow;
        end
      end
      default: writeEn = 1'b0;
    endcase
  end

  // operand capture and the stepping shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR      <= OP_RSV7;
      wordR    <= 1'b0;
      dstR     <= '0;
      workR    <= '0;
      savedR   <= '0;
      cfShR    <= 1'b0;
      oneBitR  <= 1'b0;
      zeroCntR <= 1'b0;
    end else if (ctrl.load) begin
      opR      <= blsuOp_e'(opSel);
      wordR    <= wordMode;
      dstR     <= dstIn;
      savedR   <= flagsIn;
      cfShR    <= 1'b0;
      oneBitR  <= (srcIn[CNT_W-1:0] == {{(CNT_W-1){1'b0}}, 1'b1});
      zeroCntR <= (srcIn[CNT_W-1:0] == '0);
      unique case (blsuOp_e'(opSel))
        OP_AND, OP_TEST: workR <= dstIn & srcIn;
        OP_OR:           workR <= dstIn | srcIn;
        OP_XOR:          workR <= dstIn ^ srcIn;
        OP_NOT:          workR <= ~dstIn;
        default:         workR <= dstIn;
      endcase
    end else if (ctrl.step) begin
      cfShR <= wordR ? workR[WORD_W-1] : workR[BYTE_W-1];
      workR <= {workR[WORD_W-2:0], 1'b0};
    end
  end

  // result registers, updated only at completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut   <= '0;
      resWe    <= 1'b0;
      flagsOut <= '0;
      doneOut  <= 1'b0;
    end else begin
      doneOut <= ctrl.finish;
      resWe   <= ctrl.finish && writeEn;
      if (ctrl.finish) begin
        resOut   <= writeEn ? merged : dstR;
        flagsOut <= flagsNext;
      end
    end
  end

  logic unusedHi;
  assign unusedHi = ^{HI_W{1'b0}};

endmodule

// File: rtl/blsu_top.sv
module blsu_top
  import blsu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [2:0]        opSel,
  input  logic              wordMode,
  input  logic [WORD_W-1:0] dstIn,
  input  logic [WORD_W-1:0] srcIn,
  input  logic              cfIn,
  input  logic              ofIn,
  input  logic              pfIn,
  input  logic              sfIn,
  input  logic              zfIn,
  output logic [WORD_W-1:0] resOut,
  output logic              resWe,
  output logic              cfOut,
  output logic              ofOut,
  output logic              pfOut,
  output logic              sfOut,
  output logic              zfOut,
  output logic              doneOut,
  output logic              busy
);

  blsuCtrl_t  ctrl;
  blsuFlags_t flagsIn;
  blsuFlags_t flagsOut;

  assign flagsIn = '{cf: cfIn, of: ofIn, pf: pfIn, sf: sfIn, zf: zfIn};
  assign cfOut   = flagsOut.cf;
  assign ofOut   = flagsOut.of;
  assign pfOut   = flagsOut.pf;
  assign sfOut   = flagsOut.sf;
  assign zfOut   = flagsOut.zf;

  blsu_control #(.CNT_W(CNT_W)) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .opSel   (opSel),
    .countIn (srcIn[CNT_W-1:0]),
    .ctrl    (ctrl),
    .busy    (busy)
  );

  blsu_datapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opSel    (opSel),
    .wordMode (wordMode),
    .dstIn    (dstIn),
    .srcIn    (srcIn),
    .flagsIn  (flagsIn),
    .resOut   (resOut),
    .resWe    (resWe),
    .flagsOut (flagsOut),
    .doneOut  (doneOut)
  );

endmodule

// File: rtl/blsu_checker.sv
module blsu_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [2:0]        opSel,
  input logic              wordMode,
  input logic              busy,
  input logic              doneOut,
  input logic              resWe,
  input logic [WORD_W-1:0] resOut,
  input logic              cfOut,
  input logic              ofOut,
  input logic              zfOut
);

  logic [2:0] opLat;
  logic       wordLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opLat   <= 3'd7;
      wordLat <= 1'b0;
    end else if (validIn && !busy) begin
      opLat   <= opSel;
      wordLat <= wordMode;
    end
  end

  // R10: done is a one-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R10: completion never directly follows an idle cycle
  p_idle_no_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !doneOut);

  // R10: result only moves with done
  p_res_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> $stable(resOut));

  // R1: a write only comes with done
  p_we_with_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> doneOut);

  // R3: TEST never writes
  p_test_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && opLat == 3'd4) |-> !resWe);

  // R4: bitwise operations clear CF and OF
  p_logic_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && (opLat == 3'd0 || opLat == 3'd1 || opLat == 3'd2 || opLat == 3'd4))
      |-> (!cfOut && !ofOut));

  // R5: ZF agrees with the written value at its size
  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && opLat != 3'd3)
      |-> (zfOut == (wordLat ? (resOut == '0) : (resOut[7:0] == 8'h00))));

endmodule

bind blsu_top blsu_checker #(.WORD_W(WORD_W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .opSel    (opSel),
  .wordMode (wordMode),
  .busy     (busy),
  .doneOut  (doneOut),
  .resWe    (resWe),
  .resOut   (resOut),
  .cfOut    (cfOut),
  .ofOut    (ofOut),
  .zfOut    (zfOut)
);

// File: tb/test_blsu_top.sv
`timescale 1ns/1ps
module test_blsu_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [2:0]  opSel = '0;
  logic        wordMode = 1'b1;
  logic [15:0] dstIn = '0;
  logic [15:0] srcIn = '0;
  logic        cfIn = 0, ofIn = 0, pfIn = 0, sfIn = 0, zfIn = 0;
  logic [15:0] resOut;
  logic        resWe, cfOut, ofOut, pfOut, sfOut, zfOut, doneOut, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  blsu_top i_blsu_top (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel), .wordMode(wordMode),
    .dstIn(dstIn), .srcIn(srcIn), .cfIn(cfIn), .ofIn(ofIn), .pfIn(pfIn),
    .sfIn(sfIn), .zfIn(zfIn), .resOut(resOut), .resWe(resWe), .cfOut(cfOut),
    .ofOut(ofOut), .pfOut(pfOut), .sfOut(sfOut), .zfOut(zfOut),
    .doneOut(doneOut), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: flags packed {cf,of,pf,sf,zf}
  task automatic model(input int op, input bit w, input int dst, input int src,
                       input bit [4:0] fi, output int res, output bit we,
                       output bit [4:0] fo, output int lat);
    int mask = w ? 'hFFFF : 'hFF;
    int msb  = w ? 15 : 7;
    int v;
    int c = src & 31;
    bit cf = 0;
    we  = 0;
    fo  = fi;
    lat = 1;
    v   = dst & mask;
    case (op)
      0: v = (dst & src) & mask;
      1: v = (dst | src) & mask;
      2: v = (dst ^ src) & mask;
      3: v = (~dst) & mask;
      4: v = (dst & src) & mask;
      5: begin
        for (int k = 0; k < c; k++) begin
          cf = (v >> msb) & 1;
          v  = (v << 1) & mask;
        end
        if (c > 0) lat = c + 1;
      end
      default: ;
    endcase
    if (op <= 3 || (op == 5 && c > 0)) we = 1;
    res = we ? ((dst & ~mask & 'hFFFF) | v) : dst;
    if (op <= 2 || op == 4 || (op == 5 && c > 0)) begin
      bit sf = (v >> msb) & 1;
      bit zf = (v == 0);
      bit pf = ($countones(v & 'hFF) % 2) == 0;
      bit of = 0;
      bit cfo = 0;
      if (op == 5) begin
        cfo = cf;
        of  = (c == 1) ? (sf ^ cf) : fi[3];
      end
      fo = {cfo, of, pf, sf, zf};
    end
  endtask

  task automatic run(input int op, input bit w, input int dst, input int src,
                     input bit [4:0] fi, input string tag, input bit inject);
    int res, lat;
    bit we;
    bit [4:0] fo;
    model(op, w, dst, src, fi, res, we, fo, lat);
    opSel = op[2:0]; wordMode = w; dstIn = dst[15:0]; srcIn = src[15:0];
    {cfIn, ofIn, pfIn, sfIn, zfIn} = fi;
    validIn = 1;
    @(negedge clk);
    validIn = 0;
    for (int i = 0; i <= lat; i++) begin
      if (i > 0) @(negedge clk);
      if (inject && i == 0) begin
        // R11: strobe while busy with different operands
        validIn = 1; opSel = 3'd3; dstIn = 16'h1234; srcIn = 16'h0001;
      end
      if (inject && i == 1) validIn = 0;
      if (i < lat) begin
        chk(doneOut == 0, tag, "early done (R10)", doneOut, 0);
        chk(busy == 1, tag, "busy (R11)", busy, 1);
      end else begin
        chk(doneOut == 1, tag, "done (R10)", doneOut, 1);
        chk(busy == 0, tag, "busy at done (R11)", busy, 0);
        chk(resOut == res[15:0], tag, "result", resOut, res);
        chk(resWe == we, tag, "write enable", resWe, we);
        chk({cfOut, ofOut, pfOut, sfOut, zfOut} == fo, tag, "flags cf,of,pf,sf,zf",
            {cfOut, ofOut, pfOut, sfOut, zfOut}, fo);
      end
    end
    @(negedge clk);
    chk(doneOut == 0, tag, "done pulse width (R10)", doneOut, 0);
    chk(resWe == 0, tag, "write after done (R1)", resWe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(doneOut == 0 && resWe == 0 && busy == 0, "R12", "reset controls",
        {doneOut, resWe, busy}, 0);
    chk(resOut == 0 && {cfOut, ofOut, pfOut, sfOut, zfOut} == 0, "R12", "reset data",
        resOut, 0);
    rstN = 1;
    @(negedge clk);
    run(0, 1, 'hB35E, 'h00FF, 5'b11111, "R1 R4 AND word mask", 0);
    run(1, 1, 'h3EA5, 'hFF00, 5'b11000, "R1 OR word", 0);
    run(2, 1, 'h3D69, 'h00FF, 5'b00000, "R1 XOR word", 0);
    run(1, 1, 'h0000, 'h0000, 5'b00000, "R5 zero result", 0);
    run(2, 1, 'h8000, 'h0003, 5'b00000, "R5 sign and parity", 0);
    run(3, 1, 'hF038, 'h0000, 5'b10101, "R2 NOT flags kept", 0);
    run(3, 0, 'hABCD, 'h0000, 5'b01010, "R2 R6 NOT byte", 0);
    run(4, 0, 'h7751, 'h0080, 5'b11000, "R3 TEST byte", 0);
    run(4, 1, 'hF0F0, 'h8010, 5'b11000, "R3 R4 TEST word", 0);
    run(0, 0, 'hC3A5, 'h00F0, 5'b11111, "R6 AND byte upper kept", 0);
    run(5, 1, 'hE5D3, 'h0001, 5'b00000, "R7 R8 SHL word by 1", 0);
    run(5, 0, 'h1240, 'h0001, 5'b00000, "R8 SHL byte by 1 overflow", 0);
    run(5, 0, 'h55B1, 'h0003, 5'b01000, "R7 R8 SHL byte by 3", 0);
    run(5, 1, 'h8001, 'h0010, 5'b00000, "R7 SHL word by 16", 0);
    run(5, 1, 'hFFFF, 'h0014, 5'b01000, "R7 SHL word by 20", 0);
    run(5, 1, 'h1234, 'h0020, 5'b11111, "R9 SHL count 0", 0);
    run(5, 1, 'h00F1, 'h0004, 5'b00000, "R11 strobe while busy", 1);
    run(7, 1, 'h4321, 'hFFFF, 5'b10110, "R12 reserved opcode", 0);
    run(6, 0, 'h0021, 'h0000, 5'b01001, "R12 reserved opcode 6", 0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=%0h expected=%0h", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule